// File: doc/BRIEF.md
# Serial Time Distribution Frame Receiver

This block listens to a one-wire serial stream that carries precision time from a master clock, one bit per clock cycle on the same clock as the sender, and rebuilds each frame into registered fields. A frame is fourteen 17-bit words sent back to back. Every word opens with a low start bit and then carries 16 data bits, least significant first. Word 0 is a control word. Its low four bits hold a rotating message index, and that index decides what words 1 to 5 mean. Words 6 to 13 always carry the same fields: fractional nanoseconds, a 48-bit relative nanosecond count and the period increment.

The receiver gathers the words of a frame and publishes them only after the last word has arrived. All fields from one frame then change on the same clock edge, so a downstream time keeper never sees half of an old value and half of a new one. Each group of fields has its own one-cycle update strobe. The outputs are plain registered values with strobes and have no ready signal. The serial source cannot be stalled, so back-pressure does not exist: a consumer that misses a strobe still finds the values held until the next frame.

Top module: `td_frame_rx`

## Requirements
- R1: Synchronous reset, sampled high on a clock edge, clears every output field and flag to zero and drops all strobes on that edge. The receiver then searches for a start bit again.
- R2: While searching, the first low sample on `td_sdi` is the start bit of word 0. Each word is a start slot followed by 16 data bits, least significant bit first. The 14 words follow one another with no gap, so a frame takes 238 bit times.
- R3: The outputs of a frame change on the clock edge that follows the sample of the last data bit of word 13. `cmn_stb` is high for exactly that one cycle.
- R4: Every complete frame updates the common fields. These are `rel_ns` = {w10,w9,w8}, `frac_ns` = {w7,w6}, `per_frac` = {w12,w11}, `per_ns` = w13[7:0], `rel_flag` = w0[8] and `s_lsb` = w0[9], where wN is data word N and the first word listed is the most significant. w13[15:8] is ignored.
- R5: When w0[3:0] = 0, the frame also sets `tod_ns` = {w2[13:0],w1}, `tod_flag` = w2[15] and `tod_s` = {w5,w4,w3}, and pulses `tod_stb`.
- R6: When w0[3:0] = 1, the frame sets `ofs_ns` = {w2,w1}, `drift_num` = w3, `drift_den` = w4 and `drift_state` = w5, and pulses `ofs_stb`.
- R7: When w0[3:0] = 2, the frame sets `alt_ofs_ns` = {w2,w1} and `alt_s` = {w5,w4,w3}, and pulses `alt_stb`.
- R8: Any other message index leaves every index-dependent output unchanged and pulses no index-dependent strobe. The common fields are still updated.
- R9: If a start slot after word 0 is sampled high, the frame is discarded. No output changes, no strobe pulses, and the receiver goes back to searching for a low sample.
- R10: Between two updates, each output field holds its value.
- R11: At most one index-dependent strobe is high in any cycle, and it is high only together with `cmn_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one serial bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| td_sdi | input | 1 | Serial time distribution line, idles high |
| rel_ns | output | 48 | Relative nanosecond count |
| frac_ns | output | 32 | Fractional nanoseconds |
| per_frac | output | 32 | Period increment, fractional part |
| per_ns | output | 8 | Period increment, integer nanoseconds |
| rel_flag | output | 1 | Relative timestamp was updated at the source |
| s_lsb | output | 1 | Least significant bit of time-of-day seconds |
| cmn_stb | output | 1 | Common fields updated |
| tod_ns | output | 30 | Time-of-day nanoseconds |
| tod_s | output | 48 | Time-of-day seconds |
| tod_flag | output | 1 | Time of day was updated at the source |
| tod_stb | output | 1 | Time-of-day fields updated |
| ofs_ns | output | 32 | Time-of-day offset from relative time |
| drift_num | output | 16 | Drift numerator |
| drift_den | output | 16 | Drift denominator |
| drift_state | output | 16 | Drift counter state |
| ofs_stb | output | 1 | Offset and drift fields updated |
| alt_ofs_ns | output | 32 | Alternate time-of-day offset |
| alt_s | output | 48 | Alternate time-of-day seconds |
| alt_stb | output | 1 | Alternate fields updated |

## Verification
The assertions assume that `td_sdi` changes only between clock edges, and that reset is held for at least two cycles so the hold checks compare settled zeros. They also assume the line idles high between frames, so a low level is read as a start bit only where the sender intends one. The stimulus drives the line on the falling clock edge and pads every frame with idle-high bits to 256 bit times. It makes a start slot high only on purpose, in the discarded-frame case, and it holds reset for three cycles, including once in the middle of a frame.

// File: rtl/td_rx_pkg.sv
`timescale 1ns/1ps
package td_rx_pkg;
  localparam int TD_WORD_W       = 16;
  localparam int TD_FRAME_WORDS  = 14;
  localparam int TD_WIDX_W       = $clog2(TD_FRAME_WORDS);
  localparam int TD_MSG_W        = 4;
  localparam int TD_REL_W        = 3 * TD_WORD_W;
  localparam int TD_FNS_W        = 2 * TD_WORD_W;
  localparam int TD_SEC_W        = 3 * TD_WORD_W;
  localparam int TD_OFS_W        = 2 * TD_WORD_W;
  localparam int TD_TODNS_W      = 30;
  localparam int TD_TODNS_HI     = TD_TODNS_W - TD_WORD_W;
  localparam int TD_PERNS_W      = 8;
  localparam int TD_REL_FLAG_BIT = 8;
  localparam int TD_SLSB_BIT     = 9;
  localparam int TD_TOD_FLAG_BIT = 15;

  localparam logic [TD_MSG_W-1:0] TD_MSG_TOD = TD_MSG_W'(0);
  localparam logic [TD_MSG_W-1:0] TD_MSG_OFS = TD_MSG_W'(1);
  localparam logic [TD_MSG_W-1:0] TD_MSG_ALT = TD_MSG_W'(2);

  typedef logic [TD_WORD_W-1:0] td_word_t;
endpackage

// File: rtl/td_rx_framer.sv
`timescale 1ns/1ps
// Bit and word framing: finds the frame start, checks each start slot,
// shifts in LSB-first data and hands out one word per 17 bit times.
module td_rx_framer #(
  parameter int WORD_W      = td_rx_pkg::TD_WORD_W,
  parameter int FRAME_WORDS = td_rx_pkg::TD_FRAME_WORDS
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           sdi,
  output logic                           word_vld,
  output logic [$clog2(FRAME_WORDS)-1:0] word_idx,
  output logic [WORD_W-1:0]              word
);
  localparam int WIDX_W = $clog2(FRAME_WORDS);
  localparam int BCNT_W = $clog2(WORD_W + 1);
  localparam logic [BCNT_W-1:0] LAST_BIT  = BCNT_W'(WORD_W);
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(FRAME_WORDS - 1);

  logic              hunting;
  logic [BCNT_W-1:0] bit_cnt;   // 0 = start slot, 1..WORD_W = data bits
  logic [WIDX_W-1:0] word_cnt;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    word_vld <= 1'b0;
    if (rst) begin
      hunting  <= 1'b1;
      bit_cnt  <= '0;
      word_cnt <= '0;
      shreg    <= '0;
      word     <= '0;
      word_idx <= '0;
    end else if (hunting) begin
      if (!sdi) begin
        hunting  <= 1'b0;
        bit_cnt  <= BCNT_W'(1);
        word_cnt <= '0;
      end
    end else if (bit_cnt == '0) begin
      if (sdi) begin
        hunting <= 1'b1;               // start slot high: drop the frame
      end else begin
        bit_cnt <= BCNT_W'(1);
      end
    end else begin
      shreg <= {sdi, shreg[WORD_W-1:1]};
      if (bit_cnt == LAST_BIT) begin
        word_vld <= 1'b1;
        word     <= {sdi, shreg[WORD_W-1:1]};
        word_idx <= word_cnt;
        bit_cnt  <= '0;
        if (word_cnt == LAST_WORD) begin
          hunting  <= 1'b1;
          word_cnt <= '0;
        end else begin
          word_cnt <= word_cnt + WIDX_W'(1);
        end
      end else begin
        bit_cnt <= bit_cnt + BCNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/td_rx_assembler.sv
`timescale 1ns/1ps
// Holds words 0..N-2 of the frame in flight and, when the last word arrives,
// decodes the whole frame into the output registers on one edge.
module td_rx_assembler
  import td_rx_pkg::*;
#(
  parameter int WORD_W      = TD_WORD_W,
  parameter int FRAME_WORDS = TD_FRAME_WORDS
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           word_vld,
  input  logic [$clog2(FRAME_WORDS)-1:0] word_idx,
  input  logic [WORD_W-1:0]              word,
  output logic [TD_REL_W-1:0]            rel_ns,
  output logic [TD_FNS_W-1:0]            frac_ns,
  output logic [TD_FNS_W-1:0]            per_frac,
  output logic [TD_PERNS_W-1:0]          per_ns,
  output logic                           rel_flag,
  output logic                           s_lsb,
  output logic                           cmn_stb,
  output logic [TD_TODNS_W-1:0]          tod_ns,
  output logic [TD_SEC_W-1:0]            tod_s,
  output logic                           tod_flag,
  output logic                           tod_stb,
  output logic [TD_OFS_W-1:0]            ofs_ns,
  output logic [WORD_W-1:0]              drift_num,
  output logic [WORD_W-1:0]              drift_den,
  output logic [WORD_W-1:0]              drift_state,
  output logic                           ofs_stb,
  output logic [TD_OFS_W-1:0]            alt_ofs_ns,
  output logic [TD_SEC_W-1:0]            alt_s,
  output logic                           alt_stb
);
  localparam int WIDX_W = $clog2(FRAME_WORDS);
  localparam int NSLOT  = FRAME_WORDS - 1;
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(FRAME_WORDS - 1);

  logic [WORD_W-1:0] slot [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (word_vld && word_idx == WIDX_W'(g)) q <= word;
    end
    assign slot[g] = q;
  end

  logic                commit;
  logic [TD_MSG_W-1:0] msg;
  assign commit = word_vld && (word_idx == LAST_WORD);
  assign msg    = slot[0][TD_MSG_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_ns <= '0; frac_ns <= '0; per_frac <= '0; per_ns <= '0;
      rel_flag <= 1'b0; s_lsb <= 1'b0;
      tod_ns <= '0; tod_s <= '0; tod_flag <= 1'b0;
      ofs_ns <= '0; drift_num <= '0; drift_den <= '0; drift_state <= '0;
      alt_ofs_ns <= '0; alt_s <= '0;
      cmn_stb <= 1'b0; tod_stb <= 1'b0; ofs_stb <= 1'b0; alt_stb <= 1'b0;
    end else begin
      cmn_stb <= commit;
      tod_stb <= commit && (msg == TD_MSG_TOD);
      ofs_stb <= commit && (msg == TD_MSG_OFS);
      alt_stb <= commit && (msg == TD_MSG_ALT);
      if (commit) begin
        rel_ns   <= {slot[10], slot[9], slot[8]};
        frac_ns  <= {slot[7], slot[6]};
        per_frac <= {slot[12], slot[11]};
        per_ns   <= word[TD_PERNS_W-1:0];
        rel_flag <= slot[0][TD_REL_FLAG_BIT];
        s_lsb    <= slot[0][TD_SLSB_BIT];
        case (msg)
          TD_MSG_TOD: begin
            tod_ns   <= {slot[2][TD_TODNS_HI-1:0], slot[1]};
            tod_flag <= slot[2][TD_TOD_FLAG_BIT];
            tod_s    <= {slot[5], slot[4], slot[3]};
          end
          TD_MSG_OFS: begin
            ofs_ns      <= {slot[2], slot[1]};
            drift_num   <= slot[3];
            drift_den   <= slot[4];
            drift_state <= slot[5];
          end
          TD_MSG_ALT: begin
            alt_ofs_ns <= {slot[2], slot[1]};
            alt_s      <= {slot[5], slot[4], slot[3]};
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/td_frame_rx.sv
`timescale 1ns/1ps
module td_frame_rx
  import td_rx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  td_sdi,
  output logic [TD_REL_W-1:0]   rel_ns,
  output logic [TD_FNS_W-1:0]   frac_ns,
  output logic [TD_FNS_W-1:0]   per_frac,
  output logic [TD_PERNS_W-1:0] per_ns,
  output logic                  rel_flag,
  output logic                  s_lsb,
  output logic                  cmn_stb,
  output logic [TD_TODNS_W-1:0] tod_ns,
  output logic [TD_SEC_W-1:0]   tod_s,
  output logic                  tod_flag,
  output logic                  tod_stb,
  output logic [TD_OFS_W-1:0]   ofs_ns,
  output logic [TD_WORD_W-1:0]  drift_num,
  output logic [TD_WORD_W-1:0]  drift_den,
  output logic [TD_WORD_W-1:0]  drift_state,
  output logic                  ofs_stb,
  output logic [TD_OFS_W-1:0]   alt_ofs_ns,
  output logic [TD_SEC_W-1:0]   alt_s,
  output logic                  alt_stb
);
  logic                 fr_word_vld;
  logic [TD_WIDX_W-1:0] fr_word_idx;
  td_word_t             fr_word;

  td_rx_framer #(.WORD_W(TD_WORD_W), .FRAME_WORDS(TD_FRAME_WORDS)) u_framer (
    .clk      (clk),
    .rst      (rst),
    .sdi      (td_sdi),
    .word_vld (fr_word_vld),
    .word_idx (fr_word_idx),
    .word     (fr_word)
  );

  td_rx_assembler #(.WORD_W(TD_WORD_W), .FRAME_WORDS(TD_FRAME_WORDS)) u_asm (
    .clk         (clk),
    .rst         (rst),
    .word_vld    (fr_word_vld),
    .word_idx    (fr_word_idx),
    .word        (fr_word),
    .rel_ns      (rel_ns),
    .frac_ns     (frac_ns),
    .per_frac    (per_frac),
    .per_ns      (per_ns),
    .rel_flag    (rel_flag),
    .s_lsb       (s_lsb),
    .cmn_stb     (cmn_stb),
    .tod_ns      (tod_ns),
    .tod_s       (tod_s),
    .tod_flag    (tod_flag),
    .tod_stb     (tod_stb),
    .ofs_ns      (ofs_ns),
    .drift_num   (drift_num),
    .drift_den   (drift_den),
    .drift_state (drift_state),
    .ofs_stb     (ofs_stb),
    .alt_ofs_ns  (alt_ofs_ns),
    .alt_s       (alt_s),
    .alt_stb     (alt_stb)
  );
endmodule

// File: rtl/td_frame_rx_chk.sv
`timescale 1ns/1ps
module td_frame_rx_chk
  import td_rx_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  fr_word_vld,
  input logic [TD_WIDX_W-1:0]  fr_word_idx,
  input logic [TD_REL_W-1:0]   rel_ns,
  input logic [TD_FNS_W-1:0]   frac_ns,
  input logic [TD_FNS_W-1:0]   per_frac,
  input logic [TD_PERNS_W-1:0] per_ns,
  input logic                  cmn_stb,
  input logic [TD_TODNS_W-1:0] tod_ns,
  input logic [TD_SEC_W-1:0]   tod_s,
  input logic                  tod_stb,
  input logic [TD_OFS_W-1:0]   ofs_ns,
  input logic [TD_WORD_W-1:0]  drift_num,
  input logic                  ofs_stb,
  input logic [TD_OFS_W-1:0]   alt_ofs_ns,
  input logic [TD_SEC_W-1:0]   alt_s,
  input logic                  alt_stb
);
  localparam logic [TD_WIDX_W-1:0] LAST_WORD = TD_WIDX_W'(TD_FRAME_WORDS - 1);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!cmn_stb && !tod_stb && !ofs_stb && !alt_stb &&
             rel_ns == '0 && tod_s == '0 && ofs_ns == '0 && alt_s == '0));

  a_r2_word_spacing: assert property (@(posedge clk) disable iff (rst)
    fr_word_vld |=> !fr_word_vld);

  a_r3_after_last_word: assert property (@(posedge clk) disable iff (rst)
    cmn_stb |-> $past(fr_word_vld && fr_word_idx == LAST_WORD));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cmn_stb |=> !cmn_stb);

  a_r10_common_hold: assert property (@(posedge clk) disable iff (rst)
    !cmn_stb |-> ($stable(rel_ns) && $stable(frac_ns) && $stable(per_frac) && $stable(per_ns)));

  a_r10_tod_hold: assert property (@(posedge clk) disable iff (rst)
    !tod_stb |-> ($stable(tod_ns) && $stable(tod_s)));

  a_r10_ofs_hold: assert property (@(posedge clk) disable iff (rst)
    !ofs_stb |-> ($stable(ofs_ns) && $stable(drift_num)));

  a_r10_alt_hold: assert property (@(posedge clk) disable iff (rst)
    !alt_stb |-> ($stable(alt_ofs_ns) && $stable(alt_s)));

  a_r11_one_type: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tod_stb, ofs_stb, alt_stb}));

  a_r11_type_with_common: assert property (@(posedge clk) disable iff (rst)
    (tod_stb || ofs_stb || alt_stb) |-> cmn_stb);
endmodule

bind td_frame_rx td_frame_rx_chk i_chk (.*);

// File: tb/test_td_frame_rx.sv
`timescale 1ns/1ps
module test_td_frame_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdi = 1'b1;

  logic [47:0] rel_ns;  logic [31:0] frac_ns; logic [31:0] per_frac; logic [7:0] per_ns;
  logic rel_flag, s_lsb, cmn_stb;
  logic [29:0] tod_ns;  logic [47:0] tod_s;   logic tod_flag, tod_stb;
  logic [31:0] ofs_ns;  logic [15:0] drift_num, drift_den, drift_state; logic ofs_stb;
  logic [31:0] alt_ofs_ns; logic [47:0] alt_s; logic alt_stb;

  always #10 clk = ~clk;

  td_frame_rx i_td_frame_rx (
    .clk(clk), .rst(rst), .td_sdi(sdi),
    .rel_ns(rel_ns), .frac_ns(frac_ns), .per_frac(per_frac), .per_ns(per_ns),
    .rel_flag(rel_flag), .s_lsb(s_lsb), .cmn_stb(cmn_stb),
    .tod_ns(tod_ns), .tod_s(tod_s), .tod_flag(tod_flag), .tod_stb(tod_stb),
    .ofs_ns(ofs_ns), .drift_num(drift_num), .drift_den(drift_den),
    .drift_state(drift_state), .ofs_stb(ofs_stb),
    .alt_ofs_ns(alt_ofs_ns), .alt_s(alt_s), .alt_stb(alt_stb)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string tag, input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_w [14];
  int  m_pos = -1;
  bit  m_pend = 0;
  bit  m_live = 0;
  logic [47:0] e_rel_ns = '0; logic [31:0] e_frac = '0; logic [31:0] e_per_frac = '0;
  logic [7:0] e_per_ns = '0; logic e_rel_flag = 0, e_s_lsb = 0;
  logic [29:0] e_tod_ns = '0; logic [47:0] e_tod_s = '0; logic e_tod_flag = 0;
  logic [31:0] e_ofs = '0; logic [15:0] e_num = '0, e_den = '0, e_dst = '0;
  logic [31:0] e_alt_ofs = '0; logic [47:0] e_alt_s = '0;
  logic [3:0] e_stb = '0;   // {cmn, tod, ofs, alt}

  always @(posedge clk) begin
    m_live = 1;
    e_stb = '0;
    if (rst) begin
      m_pos = -1; m_pend = 0;
      e_rel_ns = '0; e_frac = '0; e_per_frac = '0; e_per_ns = '0; e_rel_flag = 0; e_s_lsb = 0;
      e_tod_ns = '0; e_tod_s = '0; e_tod_flag = 0;
      e_ofs = '0; e_num = '0; e_den = '0; e_dst = '0; e_alt_ofs = '0; e_alt_s = '0;
    end else begin
      if (m_pend) begin
        m_pend = 0;
        e_stb[3] = 1'b1;
        e_rel_ns = {m_w[10], m_w[9], m_w[8]};
        e_frac = {m_w[7], m_w[6]};
        e_per_frac = {m_w[12], m_w[11]};
        e_per_ns = m_w[13][7:0];
        e_rel_flag = m_w[0][8];
        e_s_lsb = m_w[0][9];
        if (m_w[0][3:0] == 4'd0) begin
          e_stb[2] = 1'b1;
          e_tod_ns = {m_w[2][13:0], m_w[1]};
          e_tod_flag = m_w[2][15];
          e_tod_s = {m_w[5], m_w[4], m_w[3]};
        end else if (m_w[0][3:0] == 4'd1) begin
          e_stb[1] = 1'b1;
          e_ofs = {m_w[2], m_w[1]};
          e_num = m_w[3]; e_den = m_w[4]; e_dst = m_w[5];
        end else if (m_w[0][3:0] == 4'd2) begin
          e_stb[0] = 1'b1;
          e_alt_ofs = {m_w[2], m_w[1]};
          e_alt_s = {m_w[5], m_w[4], m_w[3]};
        end
      end
      if (m_pos < 0) begin
        if (!sdi) m_pos = 0;
      end else begin
        m_pos++;
        if (m_pos % 17 == 0) begin
          if (sdi) m_pos = -1;
        end else begin
          m_w[m_pos / 17][(m_pos % 17) - 1] = sdi;
          if (m_pos == 237) begin m_pend = 1; m_pos = -1; end
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (m_live) begin
      check("R4 common fields", {rel_ns, frac_ns, per_frac, per_ns, rel_flag, s_lsb},
            {e_rel_ns, e_frac, e_per_frac, e_per_ns, e_rel_flag, e_s_lsb});
      check("R5 tod fields", {tod_ns, tod_s, tod_flag}, {e_tod_ns, e_tod_s, e_tod_flag});
      check("R6 offset/drift fields", {ofs_ns, drift_num, drift_den, drift_state},
            {e_ofs, e_num, e_den, e_dst});
      check("R7 alternate fields", {alt_ofs_ns, alt_s}, {e_alt_ofs, e_alt_s});
      check("R3 strobes", {cmn_stb, tod_stb, ofs_stb, alt_stb}, e_stb);
    end
  end

  // strobe counters for per-frame checks
  int n_cmn = 0, n_typ = 0;
  always @(negedge clk) begin
    if (cmn_stb) n_cmn++;
    if (tod_stb || ofs_stb || alt_stb) n_typ++;
  end

  // ---------------- stimulus ----------------
  logic [15:0] tx_w [14];

  task automatic build(input logic [3:0] idx, input int seed, input logic rf,
                       input logic sl, input logic tf);
    for (int k = 0; k < 14; k++) tx_w[k] = 16'(seed * 40503 + k * 9973 + 7);
    tx_w[0] = '0;
    tx_w[0][3:0] = idx;
    tx_w[0][8] = rf;
    tx_w[0][9] = sl;
    tx_w[2][15] = tf;
    tx_w[13][15:8] = 8'hA5;
  endtask

  task automatic run_frame(input int nbits, input int abort_at);
    bit dead = 0;
    for (int bi = 0; bi < 256 && bi < nbits; bi++) begin
      logic b;
      b = 1'b1;
      if (!dead && bi < 238) begin
        if (bi % 17 == 0) begin
          if (bi / 17 == abort_at) dead = 1;
          else b = 1'b0;
        end else begin
          b = tx_w[bi / 17][(bi % 17) - 1];
        end
      end
      @(negedge clk);
      sdi = b;
    end
  endtask

  logic [47:0] p_tod_s, p_alt_s, p_rel;
  logic [31:0] p_ofs;

  task automatic snap();
    p_tod_s = tod_s; p_alt_s = alt_s; p_ofs = ofs_ns; p_rel = rel_ns;
  endtask

  task automatic check_common(input string tag);
    check({tag, " rel_ns"}, rel_ns, {tx_w[10], tx_w[9], tx_w[8]});
    check({tag, " frac_ns"}, frac_ns, {tx_w[7], tx_w[6]});
    check({tag, " period"}, {per_frac, per_ns}, {tx_w[12], tx_w[11], tx_w[13][7:0]});
    check({tag, " flags"}, {rel_flag, s_lsb}, {tx_w[0][8], tx_w[0][9]});
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 reset outputs", {rel_ns, tod_s, ofs_ns, alt_s, cmn_stb, tod_stb, ofs_stb, alt_stb}, '0);

    // R2 R4 R5: index 0 frame with all flags set
    n_cmn = 0; n_typ = 0;
    build(4'd0, 1, 1'b1, 1'b1, 1'b1);
    run_frame(256, -1);
    check_common("R4");
    check("R5 tod_ns", tod_ns, {tx_w[2][13:0], tx_w[1]});
    check("R5 tod_s", tod_s, {tx_w[5], tx_w[4], tx_w[3]});
    check("R5 tod_flag", tod_flag, 1'b1);
    check("R3 one common strobe per frame", n_cmn, 1);
    check("R11 one type strobe per frame", n_typ, 1);

    // R6: index 1
    build(4'd1, 2, 1'b0, 1'b1, 1'b0);
    run_frame(256, -1);
    check_common("R4 idx1");
    check("R6 ofs_ns", ofs_ns, {tx_w[2], tx_w[1]});
    check("R6 drift", {drift_num, drift_den, drift_state}, {tx_w[3], tx_w[4], tx_w[5]});

    // R7: index 2
    build(4'd2, 3, 1'b1, 1'b0, 1'b1);
    run_frame(256, -1);
    check("R7 alt_ofs_ns", alt_ofs_ns, {tx_w[2], tx_w[1]});
    check("R7 alt_s", alt_s, {tx_w[5], tx_w[4], tx_w[3]});

    // R8: unused indices leave type fields alone
    for (int ix = 3; ix < 16; ix += 6) begin
      snap();
      n_cmn = 0; n_typ = 0;
      build(4'(ix), 4 + ix, 1'b0, 1'b0, 1'b1);
      run_frame(256, -1);
      check("R8 type fields unchanged", {tod_s, alt_s, ofs_ns}, {p_tod_s, p_alt_s, p_ofs});
      check("R8 no type strobe", n_typ, 0);
      check_common("R8 common still updated");
    end

    // R9: start slot high in word 7 discards the frame
    snap();
    n_cmn = 0;
    build(4'd0, 21, 1'b1, 1'b1, 1'b0);
    run_frame(256, 7);
    check("R9 no strobe", n_cmn, 0);
    check("R9 outputs unchanged", {rel_ns, tod_s}, {p_rel, p_tod_s});
    build(4'd0, 22, 1'b0, 1'b1, 1'b0);
    run_frame(256, -1);
    check("R9 recovery tod_s", tod_s, {tx_w[5], tx_w[4], tx_w[3]});

    // boundary: all-ones data words
    build(4'd0, 0, 1'b1, 1'b1, 1'b1);
    for (int k = 1; k < 14; k++) tx_w[k] = 16'hFFFF;
    run_frame(256, -1);
    check("R4 all ones rel_ns", rel_ns, 48'hFFFF_FFFF_FFFF);
    check("R5 all ones tod_ns", tod_ns, 30'h3FFF_FFFF);

    // R1: reset in the middle of a frame, then recover
    build(4'd1, 31, 1'b1, 1'b1, 1'b0);
    run_frame(120, -1);
    @(negedge clk); rst = 1'b1; sdi = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 mid-frame reset", {rel_ns, ofs_ns, tod_s, alt_s, per_ns}, '0);
    repeat (140) @(negedge clk);
    check("R1 stale frame ignored after reset", cmn_stb, 1'b0);
    build(4'd1, 32, 1'b1, 1'b0, 1'b0);
    run_frame(256, -1);
    check("R6 after reset", {drift_num, drift_den, drift_state}, {tx_w[3], tx_w[4], tx_w[5]});
    check("R10 alt held at zero", alt_s, 48'h0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule